// File: doc/BRIEF.md
# Bit-Sliced Six-Function Integer ALU

A purely combinational integer arithmetic-logic unit for a datapath. It takes two WIDTH-bit operands (32 by default) and a 4-bit function code, and returns a WIDTH-bit result plus three flags: zero, signed overflow and carry out. The function code has three parts. One bit complements operand A and one bit complements operand B. The remaining two bits select one output of a per-bit multiplexer. The multiplexer inputs are the AND of the two conditioned bits, their OR, the adder sum, and a "less" input.

Each bit position works as an identical slice on a ripple carry chain. Setting the B-complement bit also forces the carry into bit 0 high, so A plus not-B plus one yields subtraction. The top slice provides the raw sign of the sum, which is used for set-less-than, and it also detects signed overflow. That sign is routed back to the less input of bit 0. The less inputs of all other bits are held at 0. NOR is obtained by complementing both operands and selecting the AND path. The block has no clock and no state.

Top module: `slice_alu`

## Requirements
- R1: Function code 4'b0000 gives result = A AND B. The function code bits are [3] complement A, [2] complement B, [1:0] multiplexer select.
- R2: Function code 4'b0001 gives result = A OR B.
- R3: Function code 4'b0010 gives result = (A + B) mod 2^WIDTH, with carry out equal to bit WIDTH of the full sum.
- R4: Function code 4'b0110 gives result = (A + ~B + 1) mod 2^WIDTH, which is A minus B. Carry out is the carry from the top slice, so it is 1 when A >= B as unsigned numbers.
- R5: Function code 4'b0111 gives result = 1 when the top bit of (A + ~B + 1) is 1, and 0 otherwise. No overflow correction is applied, so 0x80000000 versus 1 yields 0.
- R6: Function code 4'b1100 gives result = NOT (A OR B).
- R7: The zero flag is 1 exactly when every result bit is 0.
- R8: When select bit [1] is 1 (sum or less path), overflow = 1 exactly when the two conditioned operands have equal top bits and the top sum bit differs from them. When select bit [1] is 0, overflow is 0.
- R9: When select bit [1] is 1, carry out is the carry leaving the top slice. When select bit [1] is 0, carry out is 0.
- R10: With select 2'b11, result bits [WIDTH-1:1] are always 0.
- R11: Any other function code behaves per slice. A is complemented when bit [3] is 1, B is complemented and the carry into bit 0 is set when bit [2] is 1, and then the select picks AND, OR, sum or less. For example, 4'b1001 gives (~A) OR B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | Operand A |
| opb_i | input | WIDTH | Operand B |
| func_i | input | 4 | {complement A, complement B, select[1:0]} |
| res_o | output | WIDTH | Selected result |
| zero_o | output | 1 | All result bits are 0 |
| ovf_o | output | 1 | Signed overflow on the sum path |
| cout_o | output | 1 | Carry out of the top slice |

## Verification
The sum path is driven with operand pairs chosen to separate the overflow and carry cases:
- 0x7FFFFFFF plus 1 gives signed overflow with no carry.
- 0x80000000 minus 1 gives both overflow and carry.
- All-ones plus 1 gives a carry and a zero result.
- Equal operands under subtraction give a zero result with carry set.

Set-less-than is tried with:
- equal operands;
- operands of opposite sign;
- the 0x80000000 versus 1 pair, which shows that the raw sign is used rather than a corrected comparison.

Patterns of alternating bits show whether AND, OR and NOR each select the right per-bit function. An off-table function code confirms that operand complementing is independent of the select. A pseudo-random sweep over all six functions then compares every output against a bench model.

// File: rtl/slice_alu.sv
module slice_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [3:0]       func_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             cout_o
);
  localparam int MSB = WIDTH - 1;

  always_comb begin : slices
    logic             inv_a;
    logic             inv_b;
    logic [1:0]       sel;
    logic [WIDTH-1:0] pa;
    logic [WIDTH-1:0] pb;
    logic [WIDTH-1:0] sum;
    logic [WIDTH:0]   carry;
    logic             set_bit;

    inv_a    = func_i[3];
    inv_b    = func_i[2];
    sel      = func_i[1:0];
    carry[0] = inv_b;
    for (int i = 0; i < WIDTH; i++) begin
      pa[i]       = opa_i[i] ^ inv_a;
      pb[i]       = opb_i[i] ^ inv_b;
      sum[i]      = pa[i] ^ pb[i] ^ carry[i];
      carry[i+1]  = (pa[i] & pb[i]) | (pa[i] & carry[i]) | (pb[i] & carry[i]);
    end
    set_bit = sum[MSB];

    for (int i = 0; i < WIDTH; i++) begin
      case (sel)
        2'b00:   res_o[i] = pa[i] & pb[i];
        2'b01:   res_o[i] = pa[i] | pb[i];
        2'b10:   res_o[i] = sum[i];
        default: res_o[i] = (i == 0) ? set_bit : 1'b0;
      endcase
    end

    zero_o = ~|res_o;
    ovf_o  = sel[1] & (pa[MSB] == pb[MSB]) & (sum[MSB] != pa[MSB]);
    cout_o = sel[1] & carry[WIDTH];

    AST_ADD_MATCH: assert (func_i != 4'b0010 || {cout_o, res_o} == ({1'b0, opa_i} + {1'b0, opb_i})); // R3
    AST_SUB_SELF_ZERO: assert (func_i != 4'b0110 || opa_i != opb_i || (zero_o && cout_o && !ovf_o)); // R4
    AST_NOR_FORM: assert (func_i != 4'b1100 || res_o == ~(opa_i | opb_i)); // R6
    AST_LESS_UPPER_CLEAR: assert (sel != 2'b11 || res_o[MSB:1] == '0); // R10
    AST_ADD_OVF_SIGNS: assert (func_i != 4'b0010 || !ovf_o || (opa_i[MSB] == opb_i[MSB] && res_o[MSB] != opa_i[MSB])); // R8
    AST_LOGIC_NO_FLAGS: assert (sel[1] || (!ovf_o && !cout_o)); // R9
  end
endmodule

// File: tb/slice_alu_tb.sv
module slice_alu_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic [3:0]   f;
  logic         zero, ovf, cout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  slice_alu #(.WIDTH(W)) dut_i (
    .opa_i(a), .opb_i(b), .func_i(f),
    .res_o(res), .zero_o(zero), .ovf_o(ovf), .cout_o(cout)
  );

  task automatic apply(input logic [3:0] fn, input logic [W-1:0] x, input logic [W-1:0] y,
                       input string tag);
    logic [W-1:0] ca, cb, er;
    logic [W:0]   full;
    logic         ez, eo, ec, arith;
    @(negedge clk);
    f = fn; a = x; b = y;
    ca    = fn[3] ? ~x : x;
    cb    = fn[2] ? ~y : y;
    full  = {1'b0, ca} + {1'b0, cb} + {{W{1'b0}}, fn[2]};
    arith = fn[1];
    case (fn[1:0])
      2'b00:   er = ca & cb;
      2'b01:   er = ca | cb;
      2'b10:   er = full[W-1:0];
      default: er = {{(W-1){1'b0}}, full[W-1]};
    endcase
    ez = (er == '0);
    eo = arith && (ca[W-1] == cb[W-1]) && (full[W-1] != ca[W-1]);
    ec = arith && full[W];
    #1;
    checks++;
    if (res !== er || zero !== ez || ovf !== eo || cout !== ec) begin
      fails++;
      $display("FAIL %s f=%b a=%h b=%h: got res=%h z=%b v=%b c=%b, expected res=%h z=%b v=%b c=%b",
               tag, fn, x, y, res, zero, ovf, cout, er, ez, eo, ec);
    end
  endtask

  task automatic t_idle;
    apply(4'b0000, '0, '0, "R7 idle zero");
  endtask

  task automatic t_logic;
    apply(4'b0000, 32'hF0F0_A5A5, 32'hFF00_5A5A, "R1 and");
    apply(4'b0000, 32'hFFFF_FFFF, 32'h1234_5678, "R1 and pass");
    apply(4'b0001, 32'hF0F0_A5A5, 32'h0F00_5A5A, "R2 or");
    apply(4'b0001, '0, '0, "R2 R7 or zero");
    apply(4'b1100, 32'hF0F0_0000, 32'h0F0F_0000, "R6 nor");
    apply(4'b1100, 32'hFFFF_FFFF, 32'h0, "R6 R7 nor zero");
    apply(4'b1100, 32'h0, 32'h0, "R6 nor ones");
  endtask

  task automatic t_add;
    apply(4'b0010, 32'h7FFF_FFFF, 32'h1, "R3 R8 max plus one");
    apply(4'b0010, 32'hFFFF_FFFF, 32'h1, "R3 R9 R7 wrap");
    apply(4'b0010, 32'h8000_0000, 32'h8000_0000, "R8 R9 neg overflow");
    apply(4'b0010, 32'h1234_5678, 32'h1111_1111, "R3 plain");
  endtask

  task automatic t_sub;
    apply(4'b0110, 32'h8000_0000, 32'h1, "R4 R8 min minus one");
    apply(4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R4 R7 equal");
    apply(4'b0110, 32'h5, 32'h9, "R4 R9 borrow");
    apply(4'b0110, 32'h0, 32'h0, "R4 zero");
  endtask

  task automatic t_slt;
    apply(4'b0111, 32'h5, 32'h9, "R5 less");
    apply(4'b0111, 32'h9, 32'h5, "R5 R10 greater");
    apply(4'b0111, 32'h42, 32'h42, "R5 R7 equal");
    apply(4'b0111, 32'hFFFF_FFFE, 32'h1, "R5 neg vs pos");
    apply(4'b0111, 32'h8000_0000, 32'h1, "R5 raw sign no correction");
    apply(4'b0111, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 upper clear");
  endtask

  task automatic t_other;
    apply(4'b1001, 32'hF0F0_F0F0, 32'h0000_FFFF, "R11 nota or b");
    apply(4'b1010, 32'h1, 32'h5, "R11 nota plus b");
    apply(4'b0100, 32'hFFFF_0000, 32'hFF00_FF00, "R11 a and notb");
  endtask

  task automatic t_sweep;
    logic [31:0] lf = 32'hACE1_1234;
    logic [3:0]  fns [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] x, y;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      x  = lf * 32'h9E37_79B9;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      y  = (k % 7 == 0) ? x : lf ^ 32'h5A5A_0F0F;
      apply(fns[k % 6], x, y, "R1 R2 R3 R4 R5 R6 sweep");
    end
  endtask

  initial begin
    f = '0; a = '0; b = '0;
    repeat (2) @(posedge clk);
    t_idle();
    t_logic();
    t_add();
    t_sub();
    t_slt();
    t_other();
    t_sweep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule